// File: doc/BRIEF.md
# List Decoder Path Pruning Unit

This unit sits in a successive-cancellation list decoder at the point where every surviving decoding path branches on an information bit. It keeps one metric per path in its own registers. When it receives a start strobe together with two node metrics per path, one for each value of the bit, it adds each node metric to the stored metric of its path. That gives twice as many candidate metrics as there are paths. The unit then keeps the smallest half of them, ordered from the smallest up, and writes them back into its metric registers.

For every surviving slot the unit also reports two things: the path the slot must copy its history from, and the bit value that slot took. The decoder uses these to rearrange its path state before decoding continues. A clear input starts a new codeword. It sets every metric to zero and marks only path 0 as live. While the list is still filling, candidates from paths that are not yet live are never chosen over live ones. Results appear with a fixed latency and are marked by a one-cycle done pulse.

Top module: `ppu_top`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, every slot of `pm_o` reads 0 and only path 0 is live.
- R2: The expanded metric of candidate (path p, bit d) is the stored metric of p plus node metric `nm_i[(2p+d)*MW +: MW]`, saturating at 2^MW-1 (MW = Q+2).
- R3: On completion, `pm_o` slot s holds the s-th smallest candidate metric (slot 0 smallest), and these values become the stored metrics for the next prune.
- R4: Equal metrics are ordered by candidate index 2p+d, the lower index first: the lower parent first, then bit 0 before bit 1.
- R5: `parent_o[s*LW +: LW]` gives the parent path of the candidate in slot s, and `dec_o[s]` gives its bit value.
- R6: Candidates from paths at or above the live count never take a slot ahead of a live candidate. They carry metric 2^MW-1 and fill the remaining slots in index order. The live count starts at 1 and doubles after each prune, up to L.
- R7: `done_o` is high for exactly one cycle, two cycles after the cycle in which an accepted `start` was high, and the outputs are valid in that cycle.
- R8: A `start` that arrives while a prune is in its first internal cycle is ignored: it produces neither a second done pulse nor a second metric update.
- R9: `clear` takes priority over a prune in flight. That prune produces no done pulse, and the metrics stay at zero.
- R10: In every done cycle the slots of `pm_o` are non-decreasing from slot 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Start of codeword: metrics to zero, live count to one |
| start | input | 1 | One-cycle strobe launching a prune with `nm_i` |
| nm_i | input | 2*L*MW | Node metrics, candidate c = 2p+d at bits [c*MW +: MW] |
| pm_o | output | L*MW | Stored path metrics, slot s at [s*MW +: MW] |
| parent_o | output | L*LW | Parent path per slot, slot s at [s*LW +: LW] |
| dec_o | output | L | Bit value taken by each slot |
| done_o | output | 1 | One-cycle pulse when a prune completes |

## Verification
The bench feeds runs of equal metrics to test the tie order. A selector with an unstable order would swap parents or bit values between slots even though the metrics match. While the list is still filling, it puts small node metrics on paths that are not yet live. A design that ignored the live count would then choose phantom parents. Sums driven past 2^MW-1 expose wrap-around: a wrapped sum turns a bad path into the best one.

The bench also holds `start` for two cycles and raises `clear` during a prune. A design that got either case wrong would emit an extra done pulse or write back stale metrics. Random prunes are compared against an exhaustive pick-the-minimum model.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

  // Unsigned sum clipped to an upper limit.
  function automatic logic [31:0] sat_sum(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] lim);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s > {1'b0, lim}) sat_sum = lim;
    else                 sat_sum = s[31:0];
  endfunction

  // Live-path count after one split: doubles, capped at the list size.
  function automatic logic [31:0] grow_count(input logic [31:0] c, input logic [31:0] cap);
    if ({c, 1'b0} > {1'b0, cap}) grow_count = cap;
    else                         grow_count = c << 1;
  endfunction

endpackage

// File: rtl/ppu_expand.sv
module ppu_expand
  import ppu_pkg::*;
#(
  parameter int L  = 4,
  parameter int MW = 8,
  localparam int LW   = $clog2(L),
  localparam int CW   = LW + 1,
  localparam int CNTW = LW + 1,
  localparam int KW   = 1 + MW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [L*MW-1:0]     pm_flat,
  input  logic [2*L*MW-1:0]   nm_flat,
  input  logic [CNTW-1:0]     list_cnt,
  output logic [2*L*KW-1:0]   key_flat
);
  localparam int NC = 2 * L;
  localparam logic [MW-1:0] MAXM = '1;

  logic [2*L*KW-1:0] key_nxt;

  // Key = {not-live, metric, candidate index}: an ascending key order gives
  // live before not-live, then lower metric, then lower index.
  for (genvar c = 0; c < NC; c++) begin : g_cand
    localparam int P = c / 2;
    logic          inval;
    logic [MW-1:0] sum;
    assign inval = (32'(P) >= 32'(list_cnt));
    assign sum   = MW'(sat_sum(32'(pm_flat[P*MW +: MW]), 32'(nm_flat[c*MW +: MW]), 32'(MAXM)));
    assign key_nxt[c*KW +: KW] = {inval, (inval ? MAXM : sum), CW'(c)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    key_flat <= '0;
    else if (load) key_flat <= key_nxt;
  end

endmodule

// File: rtl/ppu_rank_sel.sv
module ppu_rank_sel #(
  parameter int L  = 4,
  parameter int MW = 8,
  localparam int LW = $clog2(L),
  localparam int CW = LW + 1,
  localparam int KW = 1 + MW + CW
) (
  input  logic [2*L*KW-1:0] key_flat,
  output logic [L*MW-1:0]   sel_pm,
  output logic [L*CW-1:0]   sel_idx
);
  localparam int NC = 2 * L;

  logic [KW-1:0] key  [NC];
  logic [CW-1:0] rank [NC];

  for (genvar c = 0; c < NC; c++) begin : g_key
    assign key[c] = key_flat[c*KW +: KW];
  end

  // Keys are unique (index in the LSBs), so every rank is distinct.
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      rank[c] = '0;
      for (int j = 0; j < NC; j++) begin
        if (j != c && key[j] < key[c]) rank[c] = rank[c] + CW'(1);
      end
    end
  end

  // Candidates ranked below L land in the slot equal to their rank.
  always_comb begin
    sel_pm  = '0;
    sel_idx = '0;
    for (int s = 0; s < L; s++) begin
      for (int c = 0; c < NC; c++) begin
        if (rank[c] == CW'(s)) begin
          sel_pm[s*MW +: MW]  = key[c][CW +: MW];
          sel_idx[s*CW +: CW] = key[c][CW-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/ppu_pm_regs.sv
module ppu_pm_regs
  import ppu_pkg::*;
#(
  parameter int L  = 4,
  parameter int MW = 8,
  localparam int CNTW = $clog2(L) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr,
  input  logic [L*MW-1:0]   pm_nxt,
  output logic [L*MW-1:0]   pm,
  output logic [CNTW-1:0]   list_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm       <= '0;
      list_cnt <= CNTW'(1);
    end else if (clear) begin
      pm       <= '0;
      list_cnt <= CNTW'(1);
    end else if (wr) begin
      pm       <= pm_nxt;
      list_cnt <= CNTW'(grow_count(32'(list_cnt), 32'(L)));
    end
  end

endmodule

// File: rtl/ppu_top.sv
module ppu_top #(
  parameter int L = 4,
  parameter int Q = 6,
  localparam int MW = Q + 2,
  localparam int LW = $clog2(L),
  localparam int CW = LW + 1,
  localparam int CNTW = LW + 1,
  localparam int KW = 1 + MW + CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               start,
  input  logic [2*L*MW-1:0]  nm_i,
  output logic [L*MW-1:0]    pm_o,
  output logic [L*LW-1:0]    parent_o,
  output logic [L-1:0]       dec_o,
  output logic               done_o
);
  // Named internal events, visible to the bound checker.
  logic              start_ok;
  logic              s1_vld;
  logic              wr;
  logic [CNTW-1:0]   list_cnt;
  logic [2*L*KW-1:0] key_flat;
  logic [L*MW-1:0]   sel_pm;
  logic [L*CW-1:0]   sel_idx;

  assign start_ok = start & ~s1_vld & ~clear;
  assign wr       = s1_vld & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      done_o <= 1'b0;
    end else begin
      s1_vld <= start_ok;
      done_o <= wr;
    end
  end

  ppu_expand #(.L(L), .MW(MW)) i_expand (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .pm_flat  (pm_o),
    .nm_flat  (nm_i),
    .list_cnt (list_cnt),
    .key_flat (key_flat)
  );

  ppu_rank_sel #(.L(L), .MW(MW)) i_rank (
    .key_flat (key_flat),
    .sel_pm   (sel_pm),
    .sel_idx  (sel_idx)
  );

  ppu_pm_regs #(.L(L), .MW(MW)) i_pmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .wr       (wr),
    .pm_nxt   (sel_pm),
    .pm       (pm_o),
    .list_cnt (list_cnt)
  );

  // Parent index and bit value split out of each slot's candidate index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parent_o <= '0;
      dec_o    <= '0;
    end else if (wr) begin
      for (int s = 0; s < L; s++) begin
        parent_o[s*LW +: LW] <= sel_idx[s*CW+1 +: LW];
        dec_o[s]             <= sel_idx[s*CW];
      end
    end
  end

endmodule

// File: rtl/ppu_checker.sv
module ppu_checker #(
  parameter int L  = 4,
  parameter int MW = 8,
  localparam int CNTW = $clog2(L) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              start_ok,
  input logic              done_o,
  input logic [L*MW-1:0]   pm_o,
  input logic [CNTW-1:0]   list_cnt
);
  // R7: completion comes exactly two cycles after an accepted start.
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_ok, 2));

  // R7: the done pulse lasts a single cycle.
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1: clear empties every metric and leaves one live path.
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pm_o == '0 && list_cnt == CNTW'(1)));

  // R9: a prune in flight when clear arrives never completes.
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !done_o);

  // R6: the live count doubles per prune up to L.
  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((list_cnt == CNTW'(L) && $past(list_cnt) >= CNTW'(L/2)) ||
                (list_cnt == ($past(list_cnt) << 1))));

  // R10: surviving metrics come out in non-decreasing slot order.
  for (genvar s = 1; s < L; s++) begin : g_ord
    p_sorted_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pm_o[s*MW +: MW] >= pm_o[(s-1)*MW +: MW]));
  end

endmodule

bind ppu_top ppu_checker #(.L(L), .MW(MW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .start_ok (start_ok),
  .done_o   (done_o),
  .pm_o     (pm_o),
  .list_cnt (list_cnt)
);

// File: tb/test_ppu_top.sv
`timescale 1ns/1ps
module test_ppu_top;
  localparam int L  = 4;
  localparam int Q  = 6;
  localparam int MW = Q + 2;
  localparam int LW = $clog2(L);
  localparam int NC = 2 * L;
  localparam int MAXM = (1 << MW) - 1;

  typedef int nm_t [NC];

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clear = 1'b0;
  logic              start = 1'b0;
  logic [NC*MW-1:0]  nm_i = '0;
  logic [L*MW-1:0]   pm_o;
  logic [L*LW-1:0]   parent_o;
  logic [L-1:0]      dec_o;
  logic              done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench-side model state
  int pm_m [L];
  int cnt_m;

  always #2 clk = ~clk;

  ppu_top #(.L(L), .Q(Q)) i_ppu_top (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start), .nm_i(nm_i),
    .pm_o(pm_o), .parent_o(parent_o), .dec_o(dec_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < L; p++) pm_m[p] = 0;
    cnt_m = 1;
  endtask

  task automatic check_pms(input string req);
    for (int s = 0; s < L; s++)
      check(req, $sformatf("pm slot %0d", s), int'(pm_o[s*MW +: MW]), pm_m[s]);
  endtask

  // hold = cycles start stays high (2 exercises the busy-ignore case)
  task automatic do_prune(input nm_t nm, input string req, input int hold);
    int  e [NC];
    bit  inv [NC];
    bit  taken [NC];
    int  win [L];
    for (int c = 0; c < NC; c++) begin
      inv[c]   = ((c / 2) >= cnt_m);
      e[c]     = inv[c] ? MAXM : ((pm_m[c/2] + nm[c] > MAXM) ? MAXM : pm_m[c/2] + nm[c]);
      taken[c] = 0;
    end
    // exhaustive pick of the minimum, repeated L times
    for (int s = 0; s < L; s++) begin
      int b;
      b = -1;
      for (int c = 0; c < NC; c++) begin
        if (!taken[c]) begin
          if (b < 0) b = c;
          else if (inv[c] < inv[b] || (inv[c] == inv[b] && e[c] < e[b])) b = c;
        end
      end
      taken[b] = 1;
      win[s] = b;
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) nm_i[c*MW +: MW] = MW'(nm[c]);
    start = 1'b1;
    @(negedge clk);
    if (hold < 2) start = 1'b0;
    check("R7", "done one cycle after start", int'(done_o), 0);
    @(negedge clk);
    start = 1'b0;
    check("R7", "done two cycles after start", int'(done_o), 1);
    for (int s = 0; s < L; s++) begin
      pm_m[s] = e[win[s]];
      check(req, $sformatf("pm slot %0d", s), int'(pm_o[s*MW +: MW]), e[win[s]]);
      check("R5", $sformatf("parent slot %0d", s), int'(parent_o[s*LW +: LW]), win[s] / 2);
      check("R5", $sformatf("dec slot %0d", s), int'(dec_o[s]), win[s] % 2);
    end
    cnt_m = (cnt_m * 2 > L) ? L : cnt_m * 2;
    @(negedge clk);
    check("R7", "done drops after one cycle", int'(done_o), 0);
    if (hold >= 2) begin
      @(negedge clk);
      check("R8", "no second done from held start", int'(done_o), 0);
      check_pms("R8");
    end
  endtask

  task automatic t_reset();
    check("R1", "done after reset", int'(done_o), 0);
    check_pms("R1");
  endtask

  task automatic t_fill();
    nm_t nm;
    // phantom paths get tiny metrics; they must not win
    nm = '{9, 4, 0, 0, 0, 0, 0, 0};
    do_prune(nm, "R6", 1);
    check("R6", "slot2 parent is phantom path 1", int'(parent_o[2*LW +: LW]), 1);
    nm = '{3, 7, 2, 6, 0, 0, 0, 0};
    do_prune(nm, "R6", 1);
    nm = '{1, 2, 3, 4, 5, 6, 7, 8};
    do_prune(nm, "R3", 1);
  endtask

  task automatic t_ties();
    nm_t nm;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0; model_clear();
    check_pms("R1");
    nm = '{5, 5, 1, 1, 1, 1, 1, 1};
    do_prune(nm, "R4", 1);
    check("R4", "equal metrics keep bit 0 first", int'(dec_o[0]), 0);
    nm = '{3, 3, 3, 3, 0, 0, 0, 0};
    do_prune(nm, "R4", 1);
    nm = '{2, 0, 0, 2, 0, 2, 2, 0};
    do_prune(nm, "R4", 1);
  endtask

  task automatic t_saturate();
    nm_t nm;
    nm = '{200, 250, 255, 100, 255, 255, 180, 240};
    do_prune(nm, "R2", 1);
    nm = '{255, 255, 255, 255, 255, 255, 255, 255};
    do_prune(nm, "R2", 1);
    check("R2", "saturated slot 3", int'(pm_o[3*MW +: MW]), MAXM);
  endtask

  task automatic t_busy();
    nm_t nm;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0; model_clear();
    nm = '{4, 1, 0, 0, 0, 0, 0, 0};
    do_prune(nm, "R8", 2);
  endtask

  task automatic t_abort();
    @(negedge clk);
    nm_i = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    check("R9", "no done after clear", int'(done_o), 0);
    check_pms("R9");
    @(negedge clk);
    check("R9", "still no done", int'(done_o), 0);
  endtask

  task automatic t_random();
    nm_t nm;
    for (int k = 0; k < 48; k++) begin
      if (k % 8 == 0) begin
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0; model_clear();
      end
      for (int c = 0; c < NC; c++)
        nm[c] = (k % 3 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, MAXM));
      do_prune(nm, "R3", 1);
    end
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_ties();
    t_saturate();
    t_busy();
    t_abort();
    t_random();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule